// File: doc/BRIEF.md
# SMM Memory Window Guard

This block decides, for each memory access, where the access is sent. Three targets are possible: system DRAM, the PCI/VGA side, or a blackhole that reads as all ones and drops writes. The decision depends on two small control registers and on whether the processor is in system management mode (SMM). They control three regions: the legacy SMM window at 0xA0000–0xBFFFF, a high alias of that window at 0xFEDA0000–0xFEDBFFFF, and a protected segment (TSEG) that sits directly below the top of low memory. The top of low memory is given on an input.

Software programs the registers through a simple write port. Each write carries a selector, data and a per-bit write mask. A sticky lock bit freezes the configuration until the next reset. A third 16-bit register implements a query handshake. Writing the query value 0xFFFF returns the extended TSEG size in MiB that was chosen at build time. That build-time size must not exceed 4095 MiB, and larger values are refused during elaboration.

Top module: `smm_window_guard`

## Requirements
- R1: After reset, the main control register (selector 0) reads 0x00 and the extended control register (selector 1) reads 0x00. The extended-size register (selector 2) reads 0xFFFF when the build-time extended size is nonzero, and 0x0000 otherwise.
- R2: The main control register uses bit 0 = open, bit 1 = lock and bit 2 = global enable. Whenever lock is 1, open reads 0, including on the write that sets lock.
- R3: Once lock is 1, writes to selectors 0 and 1 change nothing until reset. Lock itself can only be cleared by reset.
- R4: For a non-SMM access to 0xA0000–0xBFFFF, the route is DRAM when open=1 and high-enable=0, and PCI otherwise. Route codes are 0 = DRAM, 1 = PCI, 2 = blackhole.
- R5: The extended control register uses bit 3 = high-enable. A non-SMM access to 0xFEDA0000–0xFEDBFFFF goes to DRAM when open=1 and high-enable=1. In that case dramAddr is the access address minus 0xFEDA0000 plus 0xA0000.
- R6: An SMM access sees the legacy window as DRAM when global enable=1 and high-enable=0. It sees the high alias as DRAM when global enable=1 and high-enable=1. In every other case an SMM access is routed like a non-SMM access.
- R7: The extended control register uses bit 0 = TSEG enable and bits 2:1 = size code. The codes select 1 MiB (0), 2 MiB (1), 8 MiB (2) or the build-time extended size (3). TSEG is active only when TSEG enable and global enable are both 1.
- R8: While TSEG is active, an access in [top − size, top) gives blackhole for non-SMM and DRAM for SMM. An SMM access is never routed to blackhole.
- R9: A write to selector 2 stores the masked data. If the result equals 0xFFFF and the build-time size is nonzero, the register instead reads back that size in MiB.
- R10: A write changes only the bits whose wrMask bit is 1. Bits outside the defined fields of the two control registers always read 0.
- R11: An access that hits no window goes to DRAM below the top of low memory, and to PCI at or above it.
- R12: A write with selector 3 changes no register and no route.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register selector: 0 main control, 1 extended control, 2 extended size, 3 none |
| wrData | input | 16 | Write data (low byte used for selectors 0 and 1) |
| wrMask | input | 16 | Per-bit write enable |
| lowMemTop | input | 32 | Top of low memory in bytes |
| accAddr | input | 32 | Access address |
| accSmm | input | 1 | Access is made in SMM |
| route | output | 2 | 0 DRAM, 1 PCI, 2 blackhole |
| dramAddr | output | 32 | DRAM address of the access |
| smramReg | output | 8 | Main control register readback |
| esmramReg | output | 8 | Extended control register readback |
| extTsegReg | output | 16 | Extended-size register readback |

## Verification
The bench builds the block with an extended size of 5 MiB and a low-memory top of 128 MiB. This keeps every TSEG edge within a small, exact address range. With 5 MiB, the fourth size code produces a segment size that differs from the three fixed sizes, and the value returned by the query can be told apart from any mask pattern. A second reset near the end of the run checks that the lock clears only through reset.

// File: rtl/smm_guard_pkg.sv
package smm_guard_pkg;
  parameter int unsigned AW = 32;

  localparam logic [AW-1:0] LEG_BASE  = 32'h000A_0000;
  localparam logic [AW-1:0] WIN_BYTES = 32'h0002_0000;
  localparam logic [AW-1:0] HIGH_BASE = 32'hFEDA_0000;
  localparam int unsigned   MIB_SHIFT = 20;

  localparam int unsigned   EXT_MAX_MB = 4095;
  localparam logic [15:0]   EXT_QUERY  = 16'hFFFF;

  localparam int unsigned OPEN_B = 0;
  localparam int unsigned LOCK_B = 1;
  localparam int unsigned GEN_B  = 2;
  localparam int unsigned TSEG_B = 0;
  localparam int unsigned SZ_LO  = 1;
  localparam int unsigned HIGH_B = 3;

  localparam logic [7:0] FULL_MASK_S = 8'h07;
  localparam logic [7:0] LOCK_MASK_S = 8'h00;
  localparam logic [7:0] FULL_MASK_E = 8'h0F;
  localparam logic [7:0] LOCK_MASK_E = 8'h00;
  localparam logic [7:0] RST_S = 8'h00;
  localparam logic [7:0] RST_E = 8'h00;

  typedef enum logic [1:0] {RT_DRAM = 2'd0, RT_PCI = 2'd1, RT_HOLE = 2'd2} route_e;
  typedef enum logic [1:0] {SEL_MAIN = 2'd0, SEL_EXTC = 2'd1, SEL_SIZE = 2'd2, SEL_NONE = 2'd3} reg_sel_e;

  typedef struct packed {
    logic          openWin;
    logic          globalEn;
    logic          highEn;
    logic          tsegOn;
    logic [AW-1:0] tsegBytes;
  } smm_view_t;
endpackage

// File: rtl/smm_guard_ctrl.sv
module smm_guard_ctrl
  import smm_guard_pkg::*;
#(
  parameter int unsigned EXT_TSEG_MB = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrSel,
  input  logic [15:0] wrData,
  input  logic [15:0] wrMask,
  output smm_view_t   view,
  output logic [7:0]  smramReg,
  output logic [7:0]  esmramReg,
  output logic [15:0] extTsegReg
);
  localparam logic [15:0]   EXT_RST   = (EXT_TSEG_MB > 0) ? EXT_QUERY : 16'h0000;
  localparam logic [15:0]   EXT_MB16  = 16'(EXT_TSEG_MB);
  localparam logic [AW-1:0] EXT_BYTES = AW'(EXT_TSEG_MB) << MIB_SHIFT;

  if (EXT_TSEG_MB > EXT_MAX_MB) begin : g_bad_ext
    $error("extended TSEG size above the allowed maximum");
  end

  logic [7:0]  smramQ, esmramQ, smramNxt, esmramNxt, effS, effE;
  logic [15:0] extQ, extMerged, extNxt;
  reg_sel_e    sel;
  logic [AW-1:0] sizeBytes;

  assign sel  = reg_sel_e'(wrSel);
  assign effS = wrMask[7:0] & (smramQ[LOCK_B] ? LOCK_MASK_S : FULL_MASK_S);
  assign effE = wrMask[7:0] & (smramQ[LOCK_B] ? LOCK_MASK_E : FULL_MASK_E);

  always_comb begin
    smramNxt = (smramQ & ~effS) | (wrData[7:0] & effS);
    if (smramNxt[LOCK_B]) smramNxt[OPEN_B] = 1'b0;
    esmramNxt = (esmramQ & ~effE) | (wrData[7:0] & effE);
    extMerged = (extQ & ~wrMask) | (wrData & wrMask);
    extNxt    = (EXT_TSEG_MB > 0 && extMerged == EXT_QUERY) ? EXT_MB16 : extMerged;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      smramQ  <= RST_S;
      esmramQ <= RST_E;
      extQ    <= EXT_RST;
    end else if (wrEn) begin
      case (sel)
        SEL_MAIN: smramQ  <= smramNxt;
        SEL_EXTC: esmramQ <= esmramNxt;
        SEL_SIZE: extQ    <= extNxt;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (esmramQ[SZ_LO +: 2])
      2'd0:    sizeBytes = AW'(1) << MIB_SHIFT;
      2'd1:    sizeBytes = AW'(2) << MIB_SHIFT;
      2'd2:    sizeBytes = AW'(8) << MIB_SHIFT;
      default: sizeBytes = EXT_BYTES;
    endcase
  end

  assign view.openWin   = smramQ[OPEN_B];
  assign view.globalEn  = smramQ[GEN_B];
  assign view.highEn    = esmramQ[HIGH_B];
  assign view.tsegOn    = esmramQ[TSEG_B] & smramQ[GEN_B] & (sizeBytes != '0);
  assign view.tsegBytes = sizeBytes;

  assign smramReg   = smramQ;
  assign esmramReg  = esmramQ;
  assign extTsegReg = extQ;

  p_lock_hides_open_r2: assert property (@(posedge clk) disable iff (!rstN)
    smramReg[LOCK_B] |-> !smramReg[OPEN_B]);

  p_lock_freezes_r3: assert property (@(posedge clk) disable iff (!rstN)
    smramReg[LOCK_B] |=> (smramReg[LOCK_B] && $stable(smramReg) && $stable(esmramReg)));

  p_query_answered_r9: assert property (@(posedge clk) disable iff (!rstN)
    (EXT_TSEG_MB > 0 && wrEn && wrSel == SEL_SIZE) |=> (extTsegReg != EXT_QUERY));
endmodule

// File: rtl/smm_guard_route.sv
module smm_guard_route
  import smm_guard_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  smm_view_t     view,
  input  logic [AW-1:0] lowMemTop,
  input  logic [AW-1:0] accAddr,
  input  logic          accSmm,
  output logic [1:0]    route,
  output logic [AW-1:0] dramAddr
);
  logic [AW-1:0] tsegBase;
  logic inTseg, inLegacy, inHigh;
  route_e baseRoute, rt;

  assign tsegBase  = (lowMemTop >= view.tsegBytes) ? lowMemTop - view.tsegBytes : '0;
  assign inTseg    = view.tsegOn && accAddr >= tsegBase && accAddr < lowMemTop;
  assign inLegacy  = accAddr >= LEG_BASE && accAddr < LEG_BASE + WIN_BYTES;
  assign inHigh    = accAddr >= HIGH_BASE && accAddr < HIGH_BASE + WIN_BYTES;
  assign baseRoute = (accAddr < lowMemTop) ? RT_DRAM : RT_PCI;

  always_comb begin
    rt = baseRoute;
    if (inTseg) begin
      rt = accSmm ? RT_DRAM : RT_HOLE;
    end else if (inLegacy) begin
      if ((accSmm && view.globalEn && !view.highEn) || (view.openWin && !view.highEn))
        rt = RT_DRAM;
      else
        rt = RT_PCI;
    end else if (inHigh) begin
      if ((accSmm && view.globalEn && view.highEn) || (view.openWin && view.highEn))
        rt = RT_DRAM;
    end
  end

  assign route    = rt;
  assign dramAddr = (inHigh && !inTseg) ? accAddr - HIGH_BASE + LEG_BASE : accAddr;

  p_smm_never_hole_r8: assert property (@(posedge clk) disable iff (!rstN)
    accSmm |-> route != RT_HOLE);

  p_closed_legacy_r4: assert property (@(posedge clk) disable iff (!rstN)
    (inLegacy && !inTseg && !view.openWin && !accSmm) |-> route == RT_PCI);

  p_hidden_alias_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inHigh && !inTseg && !view.highEn) |-> route == baseRoute);
endmodule

// File: rtl/smm_window_guard.sv
module smm_window_guard
  import smm_guard_pkg::*;
#(
  parameter int unsigned EXT_TSEG_MB = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [1:0]    wrSel,
  input  logic [15:0]   wrData,
  input  logic [15:0]   wrMask,
  input  logic [AW-1:0] lowMemTop,
  input  logic [AW-1:0] accAddr,
  input  logic          accSmm,
  output logic [1:0]    route,
  output logic [AW-1:0] dramAddr,
  output logic [7:0]    smramReg,
  output logic [7:0]    esmramReg,
  output logic [15:0]   extTsegReg
);
  smm_view_t view;

  smm_guard_ctrl #(.EXT_TSEG_MB(EXT_TSEG_MB)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .wrMask(wrMask), .view(view), .smramReg(smramReg), .esmramReg(esmramReg),
    .extTsegReg(extTsegReg)
  );

  smm_guard_route i_route (
    .clk(clk), .rstN(rstN), .view(view), .lowMemTop(lowMemTop),
    .accAddr(accAddr), .accSmm(accSmm), .route(route), .dramAddr(dramAddr)
  );
endmodule

// File: tb/test_smm_window_guard.sv
module test_smm_window_guard;
  localparam int EXT_MB = 5;
  localparam longint MIB = 64'd1 << 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrSel = 2'd3;
  logic [15:0] wrData = '0, wrMask = '0;
  logic [31:0] lowMemTop = 32'h0800_0000;
  logic [31:0] accAddr = '0;
  logic accSmm = 1'b0;
  logic [1:0] route;
  logic [31:0] dramAddr;
  logic [7:0] smramReg, esmramReg;
  logic [15:0] extTsegReg;

  int total = 0, bad = 0;
  string curReq = "R1";
  logic [7:0] mS, mE;
  logic [15:0] mX;

  always #2 clk = ~clk;

  smm_window_guard #(.EXT_TSEG_MB(EXT_MB)) i_smm_window_guard (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .wrMask(wrMask), .lowMemTop(lowMemTop), .accAddr(accAddr), .accSmm(accSmm),
    .route(route), .dramAddr(dramAddr), .smramReg(smramReg),
    .esmramReg(esmramReg), .extTsegReg(extTsegReg)
  );

  // reference model of register state
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mS = 8'h00; mE = 8'h00; mX = 16'hFFFF;
    end else if (wrEn) begin
      if (wrSel == 2'd0 && !mS[1]) begin
        for (int b = 0; b < 3; b++) if (wrMask[b]) mS[b] = wrData[b];
        if (mS[1]) mS[0] = 1'b0;
      end else if (wrSel == 2'd1 && !mS[1]) begin
        for (int b = 0; b < 4; b++) if (wrMask[b]) mE[b] = wrData[b];
      end else if (wrSel == 2'd2) begin
        for (int b = 0; b < 16; b++) if (wrMask[b]) mX[b] = wrData[b];
        if (mX == 16'hFFFF) mX = 16'(EXT_MB);
      end
    end
  end

  function automatic longint tsegSize();
    case (mE[2:1])
      2'd0: return 1 * MIB;
      2'd1: return 2 * MIB;
      2'd2: return 8 * MIB;
      default: return EXT_MB * MIB;
    endcase
  endfunction

  function automatic bit hitTseg(longint a);
    longint top = lowMemTop;
    longint sz = tsegSize();
    if (!(mE[0] && mS[2])) return 0;
    return a >= top - sz && a < top;
  endfunction

  function automatic int expRoute(longint a, bit smm);
    if (hitTseg(a)) return smm ? 0 : 2;
    if (a >= 'hA0000 && a < 'hC0000) begin
      if (smm && mS[2] && !mE[3]) return 0;
      return (mS[0] && !mE[3]) ? 0 : 1;
    end
    if (a >= 'hFEDA0000 && a < 'hFEDC0000) begin
      if (smm && mS[2] && mE[3]) return 0;
      if (mS[0] && mE[3]) return 0;
    end
    return (a < longint'(lowMemTop)) ? 0 : 1;
  endfunction

  function automatic longint expDram(longint a);
    if (a >= 'hFEDA0000 && a < 'hFEDC0000 && !hitTseg(a)) return a - 'hFEDA0000 + 'hA0000;
    return a;
  endfunction

  task automatic chk(string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", curReq, what, act, exp);
    end
  endtask

  task automatic step();
    #1;
    if (rstN) begin
      chk("route", route, expRoute(accAddr, accSmm));
      chk("dramAddr", dramAddr, expDram(accAddr));
      chk("mainReg", smramReg, mS);
      chk("extCtrlReg", esmramReg, mE);
      chk("sizeReg", extTsegReg, mX);
    end
    @(negedge clk);
  endtask

  task automatic acc(logic [31:0] a, logic smm);
    accAddr = a; accSmm = smm; step();
  endtask

  task automatic wr(logic [1:0] s, logic [15:0] d, logic [15:0] m);
    wrEn = 1'b1; wrSel = s; wrData = d; wrMask = m; step();
    wrEn = 1'b0; wrSel = 2'd3;
  endtask

  initial begin
    #150000;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    curReq = "R1";
    chk("R1 main reset", smramReg, 8'h00);
    acc(32'h000A_0000, 0);
    chk("R1 size reset", extTsegReg, 16'hFFFF);

    // R10 masked write: only open changes, undefined bits stay zero
    curReq = "R10";
    wr(2'd0, 16'h00FF, 16'h0001);
    chk("R10 main after masked write", smramReg, 8'h01);
    // R4 open legacy for non-SMM
    curReq = "R4";
    acc(32'h000A_0000, 0); acc(32'h000B_FFFF, 0); acc(32'h0009_FFFF, 0);
    chk("R4 legacy open route", route, 2'd0);
    // R11 default routing
    curReq = "R11";
    acc(32'h000C_0000, 0); acc(32'h07FF_FFFF, 0); acc(32'h0800_0000, 0); acc(32'hFEDC_0000, 1);
    // R5 high alias
    curReq = "R5";
    wr(2'd1, 16'h0008, 16'hFFFF);
    acc(32'h000A_0000, 0);
    acc(32'hFEDA_0000, 0);
    chk("R5 alias dramAddr", dramAddr, 32'h000A_0000);
    acc(32'hFEDB_FFFF, 0); acc(32'hFEDC_0000, 0); acc(32'hFED9_FFFF, 0);
    // R6 SMM visibility
    curReq = "R6";
    wr(2'd0, 16'h0005, 16'h00FF);
    acc(32'hFEDA_1000, 1);
    wr(2'd0, 16'h0004, 16'h00FF);
    acc(32'hFEDA_1000, 0); acc(32'hFEDA_1000, 1); acc(32'h000A_4000, 1);
    wr(2'd1, 16'h0000, 16'hFFFF);
    acc(32'h000A_4000, 1);
    chk("R6 SMM legacy route", route, 2'd0);
    acc(32'h000A_4000, 0); acc(32'hFEDA_0000, 1);
    wr(2'd0, 16'h0000, 16'h00FF);
    acc(32'h000A_4000, 1);
    // R7/R8 TSEG for every size code
    for (int c = 0; c < 4; c++) begin
      longint sz;
      curReq = "R7";
      wr(2'd0, 16'h0004, 16'h00FF);
      wr(2'd1, 16'(1 | (c << 1)), 16'h00FF);
      sz = (c == 0) ? MIB : (c == 1) ? 2 * MIB : (c == 2) ? 8 * MIB : EXT_MB * MIB;
      acc(32'(longint'(lowMemTop) - sz), 0);
      chk("R7 lowest TSEG byte", route, 2'd2);
      acc(32'(longint'(lowMemTop) - sz - 1), 0);
      curReq = "R8";
      acc(32'(longint'(lowMemTop) - 1), 0);
      acc(32'(longint'(lowMemTop) - 1), 1);
      acc(32'(longint'(lowMemTop) - sz), 1);
      acc(lowMemTop, 0);
    end
    // R7 global enable off: TSEG inactive
    curReq = "R7";
    wr(2'd0, 16'h0000, 16'h00FF);
    acc(32'h07FF_FFFF, 0);
    chk("R7 TSEG off route", route, 2'd0);
    // R9 query handshake
    curReq = "R9";
    wr(2'd2, 16'h1234, 16'hFFFF);
    wr(2'd2, 16'hFFFF, 16'hFFFF);
    chk("R9 query answer", extTsegReg, 16'd5);
    wr(2'd2, 16'hFFFF, 16'h00FF);
    wr(2'd2, 16'hFF00, 16'hFF00);
    chk("R9 masked query answer", extTsegReg, 16'd5);
    // R12 selector 3 ignored
    curReq = "R12";
    wr(2'd0, 16'h0001, 16'h00FF);
    wr(2'd3, 16'hFFFF, 16'hFFFF);
    acc(32'h000A_0000, 0);
    chk("R12 main unchanged", smramReg, 8'h01);
    // R2 lock clears open
    curReq = "R2";
    wr(2'd1, 16'h0001, 16'h00FF);
    wr(2'd0, 16'h0007, 16'h00FF);
    chk("R2 lock write result", smramReg, 8'h06);
    acc(32'h000A_0000, 0);
    // R3 lock freezes both registers
    curReq = "R3";
    wr(2'd0, 16'h0001, 16'h00FF);
    wr(2'd1, 16'h000E, 16'h00FF);
    acc(32'h07FF_FFFF, 0);
    chk("R3 ext ctrl frozen", esmramReg, 8'h01);
    // R3 only reset clears lock; R1 again
    curReq = "R1";
    rstN = 1'b0; @(negedge clk); rstN = 1'b1;
    acc(32'h000A_0000, 0);
    chk("R1 size reset again", extTsegReg, 16'hFFFF);
    curReq = "R3";
    wr(2'd0, 16'h0001, 16'h00FF);
    acc(32'h000A_0000, 0);
    chk("R3 open writable after reset", smramReg, 8'h01);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule